// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps calendar time in packed BCD: hundredths of a second, seconds, minutes, hours, day of month, weekday, month and a two-digit year. Each single-cycle pulse on `tick_i` (nominally 100 Hz) adds one hundredth. Carries ripple upward through the fields. The hour field counts either in plain 24-hour BCD or in a 12-hour code with a PM flag, as the mode bit selects.

Software reaches the block through a byte-wide register port that holds an internal address pointer. `ptr_load_i` loads the pointer from `addr_i`. Every read or write strobe uses the current address and then advances the pointer by one. After the highest address the pointer returns to zero. A host can therefore run one write burst starting at the stop register: stop the count, clear the sub-second phase, then load all eight time fields. The port is always ready and never applies back-pressure. A strobe is accepted in every cycle it is high. Read data appears on `rdata_o` in the cycle after `rd_i`. The oscillator-control register keeps all eight bits, but only the 12-hour bit acts on the counter.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time registers at 0x00..0x07 read 0x00, 0x80, 0x00, 0x00, 0x01, 0x00, 0x01, 0x00. The oscillator-control register (0x25) reads 0x00 and the stop register (0x2E) reads 0x00.
- R2: Each accepted tick adds one to the hundredths (0x00). Hundredths wrap from 0x99 to 0x00 and carry into seconds (0x01, bits 6:0). Seconds wrap from 0x59 and carry into minutes (0x02). Minutes wrap from 0x59 and carry into hours.
- R3: With bit 5 of 0x25 clear, the hour (0x03) counts BCD 0x00..0x23. It wraps from 0x23 to 0x00 and advances the day.
- R4: With bit 5 of 0x25 set, the hour code holds BCD 1..12 in bits 4:0 and PM in bit 5. It steps 0x11->0x32, 0x32->0x21, 0x12->0x01, and 0x31->0x12, and only the last of these advances the day.
- R5: The day (0x04) wraps to 0x01 after the month's last day. April, June, September and November have 30 days; February has 29 when the year is divisible by 4 and 28 otherwise; the rest have 31. The weekday (0x05) advances with each day and wraps from 0x06 to 0x00.
- R6: The month (0x06) wraps from 0x12 to 0x01 and advances the year (0x07). The year wraps from 0x99 to 0x00.
- R7: While bit 0 of 0x2E is 1, ticks are ignored and the time does not change.
- R8: Writing 0xA4 to 0x2F sets the hundredths to 0x00 and discards a tick in that cycle. Writing any other value to 0x2F has no effect. 0x2F always reads 0x00.
- R9: Bit 7 of the seconds register is the oscillator-stopped flag. Reset sets it, and a pulse on `osc_fail_i` sets it. A seconds write with bit 7 = 0 clears it and one with bit 7 = 1 leaves it unchanged. `osc_fail_i` wins over a clear in the same cycle.
- R10: Each read or write strobe advances the pointer by one. From 0x2F it advances to 0x00. With `ptr_load_i` high, the access uses `addr_i`.
- R11: A write to a time register appears in the next cycle, and any tick in that cycle is discarded.
- R12: Reads return data the cycle after `rd_i`. Addresses outside 0x00..0x07, 0x25, 0x2E and 0x2F read 0x00 and ignore writes. 0x25 reads back all eight written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle hundredth tick |
| osc_fail_i | input | 1 | Pulse that sets the oscillator-stopped flag |
| ptr_load_i | input | 1 | Load the address pointer from `addr_i` (the access in this cycle uses `addr_i`) |
| addr_i | input | 6 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |

## Verification
On every cycle, assertions check these behaviours:
- the hundredths rollover;
- the freeze while stopped;
- the effect of the prescaler-clear command;
- the priority of a register write over a tick;
- setting of the stopped flag;
- the pointer's increment and wrap.

The hour codes in both modes, month lengths and leap Februaries, and the year and weekday wraps take long carry chains. Only the bench scenarios show them: they load times next to a boundary and compare full burst reads against a binary reference model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W   = 8;
  localparam int OFS_HUND = 0;
  localparam int OFS_SEC  = 1;
  localparam int OFS_MIN  = 2;
  localparam int OFS_HOUR = 3;
  localparam int OFS_DAY  = 4;
  localparam int OFS_WDAY = 5;
  localparam int OFS_MON  = 6;
  localparam int OFS_YEAR = 7;
  localparam int OFS_OSC  = 'h25;
  localparam int OFS_STOP = 'h2E;
  localparam int OFS_CMD  = 'h2F;
  localparam logic [BYTE_W-1:0] CMD_CLR_PHASE = 8'hA4;
  localparam int MODE12_BIT = 5;

  typedef struct packed {
    logic [BYTE_W-1:0] hund;
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] day;
    logic [BYTE_W-1:0] wday;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] year;
  } cal_time_t;

  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction
endpackage

// File: rtl/rtc_burst_ptr.sv
module rtc_burst_ptr #(
  parameter int ADDR_W   = 6,
  parameter int TOP_ADDR = 'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] acc_addr_o
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(TOP_ADDR);
  logic [ADDR_W-1:0] ptr_q;

  assign acc_addr_o = load_i ? addr_i : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (step_i)  ptr_q <= (acc_addr_o >= TOP) ? '0 : acc_addr_o + 1'b1;
    else if (load_i)  ptr_q <= addr_i;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && acc_addr_o == TOP) |=> ptr_q == '0);  // R10
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && acc_addr_o < TOP) |=> ptr_q == $past(acc_addr_o) + 1'b1);  // R10
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_cal_pkg::*;
(
  input  logic [BYTE_W-1:0] hour_i,
  input  logic              mode12_i,
  output logic [BYTE_W-1:0] next_o,
  output logic              day_carry_o
);
  logic [4:0]        hr12;
  logic              pm;
  logic [BYTE_W-1:0] inc12;

  assign hr12  = hour_i[4:0];
  assign pm    = hour_i[5];
  assign inc12 = bcd_inc({3'b000, hr12});

  always_comb begin
    next_o      = '0;
    day_carry_o = 1'b0;
    if (mode12_i) begin
      if (hr12 == 5'h12) begin
        next_o = {2'b00, pm, 5'h01};
      end else if (hr12 == 5'h11) begin
        next_o      = {2'b00, ~pm, 5'h12};
        day_carry_o = pm;
      end else begin
        next_o = {2'b00, pm, inc12[4:0]};
      end
    end else begin
      if (hour_i[5:0] >= 6'h23) begin
        next_o      = '0;
        day_carry_o = 1'b1;
      end else begin
        next_o = bcd_inc({2'b00, hour_i[5:0]});
      end
    end
  end
endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
  import rtc_cal_pkg::*;
(
  input  logic [BYTE_W-1:0] day_i,
  input  logic [BYTE_W-1:0] wday_i,
  input  logic [BYTE_W-1:0] mon_i,
  input  logic [BYTE_W-1:0] year_i,
  output logic [BYTE_W-1:0] day_o,
  output logic [BYTE_W-1:0] wday_o,
  output logic [BYTE_W-1:0] mon_o,
  output logic [BYTE_W-1:0] year_o
);
  logic [4:0]        leap_sum;
  logic              leap;
  logic [BYTE_W-1:0] last_day;
  logic              month_end;

  // ten is 2 mod 4, so year mod 4 = (2*tens[0] + ones) mod 4
  assign leap_sum = {3'b000, year_i[4], 1'b0} + {1'b0, year_i[3:0]};
  assign leap     = (leap_sum[1:0] == 2'b00);

  always_comb begin
    case (mon_i)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign month_end = (day_i >= last_day);

  always_comb begin
    wday_o = (wday_i >= 8'h06) ? 8'h00 : wday_i + 8'h01;
    day_o  = month_end ? 8'h01 : bcd_inc(day_i);
    mon_o  = mon_i;
    year_o = year_i;
    if (month_end) begin
      if (mon_i >= 8'h12) begin
        mon_o  = 8'h01;
        year_o = (year_i >= 8'h99) ? 8'h00 : bcd_inc(year_i);
      end else begin
        mon_o = bcd_inc(mon_i);
      end
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int TOP_ADDR = 'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              osc_fail_i,
  input  logic              ptr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(OFS_YEAR);
  localparam logic [ADDR_W-1:0] A_HUND = ADDR_W'(OFS_HUND);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFS_SEC);
  localparam logic [ADDR_W-1:0] A_OSC  = ADDR_W'(OFS_OSC);
  localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(OFS_STOP);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);

  cal_time_t         t_q;
  logic              osf_q;
  logic [BYTE_W-1:0] osc_ctrl_q;
  logic              stop_q;
  logic [BYTE_W-1:0] rdata_q;
  logic [ADDR_W-1:0] acc_addr;

  logic              time_wr, clr_cmd, tick_go;
  logic              c_hund, c_sec, c_min, c_hour;
  logic [BYTE_W-1:0] hour_nx;
  logic              hour_carry;
  logic [BYTE_W-1:0] day_nx, wday_nx, mon_nx, year_nx;

  rtc_burst_ptr #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_load_i), .addr_i(addr_i),
    .step_i(wr_i | rd_i), .acc_addr_o(acc_addr)
  );

  rtc_hour_step u_hour (
    .hour_i(t_q.hour), .mode12_i(osc_ctrl_q[MODE12_BIT]),
    .next_o(hour_nx), .day_carry_o(hour_carry)
  );

  rtc_date_step u_date (
    .day_i(t_q.day), .wday_i(t_q.wday), .mon_i(t_q.mon), .year_i(t_q.year),
    .day_o(day_nx), .wday_o(wday_nx), .mon_o(mon_nx), .year_o(year_nx)
  );

  assign time_wr = wr_i && (acc_addr <= A_YEAR);
  assign clr_cmd = wr_i && (acc_addr == A_CMD) && (wdata_i == CMD_CLR_PHASE);
  assign tick_go = tick_i && !stop_q && !time_wr && !clr_cmd;
  assign c_hund  = tick_go && (t_q.hund >= 8'h99);
  assign c_sec   = c_hund && (t_q.sec >= 8'h59);
  assign c_min   = c_sec && (t_q.min >= 8'h59);
  assign c_hour  = c_min && hour_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '{hund: 8'h00, sec: 8'h00, min: 8'h00, hour: 8'h00,
               day: 8'h01, wday: 8'h00, mon: 8'h01, year: 8'h00};
    end else if (time_wr) begin
      case (acc_addr[2:0])
        3'd0: t_q.hund <= wdata_i;
        3'd1: t_q.sec  <= {1'b0, wdata_i[6:0]};
        3'd2: t_q.min  <= wdata_i;
        3'd3: t_q.hour <= wdata_i;
        3'd4: t_q.day  <= wdata_i;
        3'd5: t_q.wday <= wdata_i;
        3'd6: t_q.mon  <= wdata_i;
        default: t_q.year <= wdata_i;
      endcase
    end else if (clr_cmd) begin
      t_q.hund <= 8'h00;
    end else if (tick_go) begin
      t_q.hund <= c_hund ? 8'h00 : bcd_inc(t_q.hund);
      if (c_hund) t_q.sec  <= c_sec ? 8'h00 : bcd_inc(t_q.sec);
      if (c_sec)  t_q.min  <= c_min ? 8'h00 : bcd_inc(t_q.min);
      if (c_min)  t_q.hour <= hour_nx;
      if (c_hour) begin
        t_q.day  <= day_nx;
        t_q.wday <= wday_nx;
        t_q.mon  <= mon_nx;
        t_q.year <= year_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osf_q      <= 1'b1;
      osc_ctrl_q <= '0;
      stop_q     <= 1'b0;
    end else begin
      if (osc_fail_i)                         osf_q <= 1'b1;
      else if (wr_i && acc_addr == A_SEC)     osf_q <= osf_q & wdata_i[7];
      if (wr_i && acc_addr == A_OSC)          osc_ctrl_q <= wdata_i;
      if (wr_i && acc_addr == A_STOP)         stop_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      case (acc_addr)
        6'h00:   rdata_q <= t_q.hund;
        6'h01:   rdata_q <= {osf_q, t_q.sec[6:0]};
        6'h02:   rdata_q <= t_q.min;
        6'h03:   rdata_q <= t_q.hour;
        6'h04:   rdata_q <= t_q.day;
        6'h05:   rdata_q <= t_q.wday;
        6'h06:   rdata_q <= t_q.mon;
        6'h07:   rdata_q <= t_q.year;
        A_OSC:   rdata_q <= osc_ctrl_q;
        A_STOP:  rdata_q <= {7'b0, stop_q};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  AST_HUND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !stop_q && !wr_i && t_q.hund == 8'h99) |=> t_q.hund == 8'h00);  // R2
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_i) |=> $stable(t_q));  // R7
  AST_CLR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && acc_addr == A_CMD && wdata_i == 8'hA4) |=> t_q.hund == 8'h00);  // R8
  AST_OSF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail_i |=> osf_q);  // R9
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && acc_addr == A_HUND) |=> t_q.hund == $past(wdata_i));  // R11
endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, osc_fail_i = 1'b0, ptr_load_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int n_chk = 0, n_bad = 0;
  int e_h, e_s, e_m, e_hr, e_d, e_wd, e_mo, e_yr;
  bit e_osf, m12;
  logic [7:0] v;

  always #2 clk = ~clk;

  rtc_calendar_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_fail_i(osc_fail_i),
    .ptr_load_i(ptr_load_i), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .rdata_o(rdata_o)
  );

  function automatic logic [7:0] bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic logic [7:0] hcode(input int h24, input bit mode12);
    int h;
    if (!mode12) return bcd(h24);
    h = h24 % 12;
    if (h == 0) h = 12;
    return bcd(h) | ((h24 >= 12) ? 8'h20 : 8'h00);
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic adv_model();
    e_h++;
    if (e_h == 100) begin
      e_h = 0; e_s++;
      if (e_s == 60) begin
        e_s = 0; e_m++;
        if (e_m == 60) begin
          e_m = 0; e_hr++;
          if (e_hr == 24) begin
            e_hr = 0; e_d++; e_wd = (e_wd + 1) % 7;
            if (e_d > mdays(e_mo, e_yr)) begin
              e_d = 1; e_mo++;
              if (e_mo == 13) begin e_mo = 1; e_yr = (e_yr + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr_at(input logic [5:0] a, input logic [7:0] d);
    ptr_load_i = 1; addr_i = a; wr_i = 1; wdata_i = d;
    cyc();
    ptr_load_i = 0; wr_i = 0;
  endtask

  task automatic wr_nx(input logic [7:0] d);
    wr_i = 1; wdata_i = d; cyc(); wr_i = 0;
  endtask

  task automatic rd_at(input logic [5:0] a, output logic [7:0] q);
    ptr_load_i = 1; addr_i = a; rd_i = 1;
    cyc();
    ptr_load_i = 0; rd_i = 0; q = rdata_o;
  endtask

  task automatic rd_nx(output logic [7:0] q);
    rd_i = 1; cyc(); rd_i = 0; q = rdata_o;
  endtask

  task automatic ticks(input int n);
    tick_i = 1;
    repeat (n) cyc();
    tick_i = 0;
    for (int i = 0; i < n; i++) adv_model();
  endtask

  // burst from the stop register: stop, clear phase, wrap to 0x00, load all fields (R10)
  task automatic load_time();
    wr_at(6'h25, m12 ? 8'h20 : 8'h00);
    wr_at(6'h2E, 8'h01);
    wr_nx(8'hA4);
    wr_nx(bcd(e_h)); wr_nx(bcd(e_s)); wr_nx(bcd(e_m)); wr_nx(hcode(e_hr, m12));
    wr_nx(bcd(e_d)); wr_nx(bcd(e_wd)); wr_nx(bcd(e_mo)); wr_nx(bcd(e_yr));
    e_osf = 0;
    wr_at(6'h2E, 8'h00);
  endtask

  task automatic check_time(input string req);
    logic [7:0] q;
    rd_at(6'h00, q); chk(req, q, bcd(e_h));
    rd_nx(q); chk(req, q, {e_osf, bcd(e_s)[6:0]});
    rd_nx(q); chk(req, q, bcd(e_m));
    rd_nx(q); chk(req, q, hcode(e_hr, m12));
    rd_nx(q); chk(req, q, bcd(e_d));
    rd_nx(q); chk(req, q, bcd(e_wd));
    rd_nx(q); chk(req, q, bcd(e_mo));
    rd_nx(q); chk(req, q, bcd(e_yr));
  endtask

  task automatic set_t(input int h, s, m, hr, d, wd, mo, yr);
    e_h = h; e_s = s; e_m = m; e_hr = hr; e_d = d; e_wd = wd; e_mo = mo; e_yr = yr;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();

    // R1 reset state
    set_t(0, 0, 0, 0, 1, 0, 1, 0); e_osf = 1; m12 = 0;
    check_time("R1");
    rd_at(6'h25, v); chk("R1", v, 8'h00);
    rd_at(6'h2E, v); chk("R1", v, 8'h00);

    // R12 register storage, unmapped and command reads
    wr_at(6'h25, 8'h9A); rd_at(6'h25, v); chk("R12", v, 8'h9A);
    wr_at(6'h10, 8'h55); rd_at(6'h10, v); chk("R12", v, 8'h00);
    rd_at(6'h2F, v); chk("R12", v, 8'h00);
    wr_at(6'h25, 8'h00);

    // R2 / R3 / R5 carries in 24-hour mode
    set_t(99, 59, 59, 23, 28, 6, 2, 24); load_time(); ticks(1); check_time("R5");
    set_t(99, 59, 59, 23, 29, 3, 2, 24); load_time(); ticks(1); check_time("R5");
    set_t(99, 59, 59, 23, 28, 2, 2, 23); load_time(); ticks(1); check_time("R5");
    set_t(99, 59, 59, 23, 30, 1, 4, 10); load_time(); ticks(1); check_time("R3");
    set_t(95, 58, 12, 7, 15, 4, 8, 50);  load_time(); ticks(10); check_time("R2");
    // R6 month and year wrap
    set_t(99, 59, 59, 23, 31, 5, 12, 99); load_time(); ticks(1); check_time("R6");

    // R10 wrap on reads: 0x2F then 0x00
    rd_at(6'h2F, v); chk("R10", v, 8'h00);
    rd_nx(v); chk("R10", v, bcd(e_h));

    // R4 12-hour codes
    m12 = 1;
    set_t(99, 59, 59, 11, 10, 1, 3, 21); load_time(); ticks(1); check_time("R4");
    set_t(99, 59, 59, 12, 10, 1, 3, 21); load_time(); ticks(1); check_time("R4");
    set_t(99, 59, 59, 23, 10, 1, 3, 21); load_time(); ticks(1); check_time("R4");
    set_t(99, 59, 59, 0, 10, 1, 3, 21);  load_time(); ticks(1); check_time("R4");
    m12 = 0;
    set_t(10, 20, 30, 4, 5, 2, 6, 7); load_time();

    // R7 stop freezes
    wr_at(6'h2E, 8'h01);
    tick_i = 1; repeat (5) cyc(); tick_i = 0;
    rd_at(6'h2E, v); chk("R7", v, 8'h01);
    check_time("R7");
    wr_at(6'h2E, 8'h00);

    // R8 phase clear command
    ticks(7);
    tick_i = 1; wr_at(6'h2F, 8'hA4); tick_i = 0; e_h = 0;
    check_time("R8");
    ticks(3);
    wr_at(6'h2F, 8'h55);
    check_time("R8");

    // R9 oscillator-stopped flag
    osc_fail_i = 1; cyc(); osc_fail_i = 0; e_osf = 1;
    check_time("R9");
    wr_at(6'h01, 8'h80 | bcd(e_s)); check_time("R9");
    wr_at(6'h01, bcd(e_s)); e_osf = 0; check_time("R9");
    osc_fail_i = 1; wr_at(6'h01, bcd(e_s)); osc_fail_i = 0; e_osf = 1;
    check_time("R9");
    wr_at(6'h01, bcd(e_s)); e_osf = 0;

    // R11 write beats tick
    tick_i = 1; wr_at(6'h00, 8'h42); tick_i = 0; e_h = 42;
    check_time("R11");
    tick_i = 1; wr_at(6'h07, bcd(e_yr)); tick_i = 0;
    check_time("R11");

    // random loads near boundaries, random tick runs
    for (int it = 0; it < 30; it++) begin
      m12 = bit'($urandom % 2);
      e_yr = $urandom % 100;
      e_mo = 1 + $urandom % 12;
      e_d  = ($urandom % 2) ? mdays(e_mo, e_yr) : 1 + $urandom % mdays(e_mo, e_yr);
      e_wd = $urandom % 7;
      e_hr = ($urandom % 2) ? (($urandom % 2) ? 23 : 11) : $urandom % 24;
      e_m  = ($urandom % 2) ? 59 : $urandom % 60;
      e_s  = ($urandom % 2) ? 59 : $urandom % 60;
      e_h  = 80 + $urandom % 20;
      load_time();
      ticks(1 + $urandom % 150);
      check_time("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule